// File: doc/BRIEF.md
# Page-Relative Conditional Jump Resolver

This block decides the outcome of a one-byte-operand conditional jump and computes the program counter that follows it. The surrounding sequencer presents a 4-bit condition code, the current 16-bit program counter (already advanced to the address of the operand byte), the operand byte itself, the accumulator-zero and carry flags, and four external sense lines. It raises a one-cycle resolve strobe. On the next clock edge the block registers the new program counter and flags whether the jump was taken.

The three low bits of the code pick a condition. The top bit inverts it. A taken jump overwrites only the low byte of the program counter, so the target always lies in the current 256-byte page. A jump that is not taken steps the counter past the operand byte. With code 8, the block acts as an unconditional skip. The external sense lines are asynchronous, so each one passes through a two-flop synchronizer before it is tested. The reset input is asserted asynchronously and released in step with the clock.

Top module: `pgbranch_unit`

## Requirements
- R1: While reset is held, and until the first resolve after it, `pc_next` is 0x0000 and `jump_taken` is 0.
- R2: Condition code 0x0 is always taken. `pc_next` becomes {`pc_cur[15:8]`, `jump_operand`}, which keeps the upper byte of the current counter.
- R3: Condition code 0x8 is never taken (skip). `pc_next` becomes `pc_cur + 1`.
- R4: Code 0x2 is taken when `acc_zero` is 1. Code 0xA is taken when `acc_zero` is 0.
- R5: Code 0x3 is taken when `carry_flag` is 1. Code 0xB is taken when `carry_flag` is 0.
- R6: Codes 0x4 to 0x7 are taken when the synchronized `sense_in` bit 0, 1, 2 or 3 respectively is 1. Codes 0xC to 0xF are taken when that bit is 0.
- R7: The undefined codes 0x1 and 0x9 behave exactly like 0x0 and 0x8.
- R8: The not-taken increment wraps across the full 16 bits (0xFFFF becomes 0x0000). A taken jump from 0x12FF to operand 0x00 yields 0x1200.
- R9: Results appear in the cycle after the edge that samples `resolve`. `jump_taken` is high for exactly that one cycle. With no `resolve`, `pc_next` holds and `jump_taken` is 0.
- R10: A change on `sense_in` is not seen by a resolve sampled at the first or second clock edge after the change. It is seen by a resolve sampled at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resolve | input | 1 | One-cycle strobe that samples the inputs below |
| cond_code | input | 4 | Condition selector; bit 3 inverts |
| pc_cur | input | 16 | Program counter pointing at the operand byte |
| jump_operand | input | 8 | Operand byte: new low byte of the counter |
| acc_zero | input | 1 | Accumulator equals zero |
| carry_flag | input | 1 | Carry / borrow flag |
| sense_in | input | 4 | Asynchronous external sense lines, bit 0 first |
| pc_next | output | 16 | Registered next program counter |
| jump_taken | output | 1 | One-cycle pulse when the resolved jump was taken |

## Verification
A wrong selector or inversion produces the wrong `jump_taken` and the wrong `pc_next` in the very cycle after the resolve strobe. The error also persists in `pc_next` until the next resolve. A corrupted page byte or increment shows up at that same cycle as an address differing from {page, operand} or counter+1. A synchronizer with the wrong depth shifts, by one edge or more, the first resolve that observes a new sense level, and the depth check catches that shift. A stuck or stretched taken register shows up one cycle later, as a pulse that outlasts its resolve.

// File: rtl/pgbranch_pkg.sv
package pgbranch_pkg;

  localparam int unsigned CODE_W  = 4;
  localparam int unsigned SENSE_N = 4;

  typedef enum logic [2:0] {
    SEL_ALWAYS = 3'd0,
    SEL_UNDEF  = 3'd1,
    SEL_ZERO   = 3'd2,
    SEL_CARRY  = 3'd3,
    SEL_SNS0   = 3'd4,
    SEL_SNS1   = 3'd5,
    SEL_SNS2   = 3'd6,
    SEL_SNS3   = 3'd7
  } cond_sel_e;

endpackage

// File: rtl/pgbranch_rst_sync.sv
module pgbranch_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pgbranch_flag_sync.sv
module pgbranch_flag_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = async_in;
      end else begin : g_next
        always_comb stage_d[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else begin
          stage_q[g] <= stage_d[g];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    stage_q[0] == $past(async_in)); // R10

  generate
    for (g = 1; g < STAGES; g++) begin : g_chk
      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        stage_q[g] == $past(stage_q[g-1])); // R10
    end
  endgenerate

endmodule

// File: rtl/pgbranch_cond.sv
module pgbranch_cond
  import pgbranch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  cond_code,
  input  logic               acc_zero,
  input  logic               carry_flag,
  input  logic [SENSE_N-1:0] sense_sync,
  output logic               take
);

  cond_sel_e sel;
  logic      invert;
  logic      raw;

  always_comb begin
    sel    = cond_sel_e'(cond_code[2:0]);
    invert = cond_code[3];
    unique case (sel)
      SEL_ALWAYS, SEL_UNDEF: raw = 1'b1;
      SEL_ZERO:              raw = acc_zero;
      SEL_CARRY:             raw = carry_flag;
      SEL_SNS0:              raw = sense_sync[0];
      SEL_SNS1:              raw = sense_sync[1];
      SEL_SNS2:              raw = sense_sync[2];
      SEL_SNS3:              raw = sense_sync[3];
      default:               raw = 1'b1;
    endcase
    take = raw ^ invert;
  end

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code[2:1] == 2'b00 && !cond_code[3]) |-> take); // R2

  AST_SKIP_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code[2:1] == 2'b00 && cond_code[3]) |-> !take); // R3

endmodule

// File: rtl/pgbranch_pc.sv
module pgbranch_pc #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OPD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resolve,
  input  logic             take,
  input  logic [PC_W-1:0]  pc_cur,
  input  logic [OPD_W-1:0] operand,
  output logic [PC_W-1:0]  pc_next,
  output logic             taken
);

  localparam int unsigned PAGE_W = PC_W - OPD_W;

  logic [PC_W-1:0] pc_d, pc_q;
  logic            taken_d, taken_q;
  logic            pc_en;

  always_comb begin
    pc_en   = resolve;
    taken_d = resolve & take;
    if (take) pc_d = {pc_cur[PC_W-1 -: PAGE_W], operand};
    else      pc_d = pc_cur + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= taken_d;
      if (pc_en) pc_q <= pc_d;
    end
  end

  assign pc_next = pc_q;
  assign taken   = taken_q;

  AST_TAKEN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |-> pc_q[PC_W-1 -: PAGE_W] == $past(pc_cur[PC_W-1 -: PAGE_W])); // R2

  AST_TAKEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |-> pc_q[OPD_W-1:0] == $past(operand)); // R2

  AST_STEP_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(resolve) && !taken_q) |-> pc_q == $past(pc_cur) + PC_W'(1)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve |=> ($stable(pc_q) && !taken_q)); // R9

endmodule

// File: rtl/pgbranch_unit.sv
module pgbranch_unit
  import pgbranch_pkg::*;
#(
  parameter int unsigned PC_W        = 16,
  parameter int unsigned OPD_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               resolve,
  input  logic [CODE_W-1:0]  cond_code,
  input  logic [PC_W-1:0]    pc_cur,
  input  logic [OPD_W-1:0]   jump_operand,
  input  logic               acc_zero,
  input  logic               carry_flag,
  input  logic [SENSE_N-1:0] sense_in,
  output logic [PC_W-1:0]    pc_next,
  output logic               jump_taken
);

  logic               rst_sync_n;
  logic [SENSE_N-1:0] sense_sync;
  logic               take;

  pgbranch_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pgbranch_flag_sync #(.WIDTH(SENSE_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (sense_in),
    .sync_out (sense_sync)
  );

  pgbranch_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cond_code  (cond_code),
    .acc_zero   (acc_zero),
    .carry_flag (carry_flag),
    .sense_sync (sense_sync),
    .take       (take)
  );

  pgbranch_pc #(.PC_W(PC_W), .OPD_W(OPD_W)) u_pc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .resolve (resolve),
    .take    (take),
    .pc_cur  (pc_cur),
    .operand (jump_operand),
    .pc_next (pc_next),
    .taken   (jump_taken)
  );

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (jump_taken && !$past(resolve, 2)) |=> !jump_taken); // R9

  AST_UNDEF_AS_ALWAYS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (resolve && cond_code == 4'h1) |=> jump_taken); // R7

  AST_UNDEF_AS_SKIP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (resolve && cond_code == 4'h9) |=> !jump_taken); // R7

endmodule

// File: tb/pgbranch_unit_tb_top.sv
`timescale 1ns/1ps
module pgbranch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        resolve;
  logic [3:0]  cond_code;
  logic [15:0] pc_cur;
  logic [7:0]  jump_operand;
  logic        acc_zero;
  logic        carry_flag;
  logic [3:0]  sense_in;
  logic [15:0] pc_next;
  logic        jump_taken;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pgbranch_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .resolve      (resolve),
    .cond_code    (cond_code),
    .pc_cur       (pc_cur),
    .jump_operand (jump_operand),
    .acc_zero     (acc_zero),
    .carry_flag   (carry_flag),
    .sense_in     (sense_in),
    .pc_next      (pc_next),
    .jump_taken   (jump_taken)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [15:0] exp_pc, input logic exp_tk);
    checks++;
    if (pc_next !== exp_pc || jump_taken !== exp_tk) begin
      errors++;
      $display("FAIL %s: actual pc=%h taken=%b, expected pc=%h taken=%b",
               tag, pc_next, jump_taken, exp_pc, exp_tk);
    end
  endtask

  function automatic logic model_take(input logic [3:0] c, input logic z,
                                      input logic cf, input logic [3:0] s);
    logic r;
    case (c[2:0])
      3'd0, 3'd1: r = 1'b1;
      3'd2:       r = z;
      3'd3:       r = cf;
      default:    r = s[c[2:0] - 3'd4];
    endcase
    return r ^ c[3];
  endfunction

  task automatic settle_sense(input logic [3:0] s);
    @(negedge clk);
    sense_in = s;
    repeat (3) @(negedge clk);
  endtask

  task automatic resolve_one(input string tag, input logic [3:0] c, input logic [15:0] pc,
                             input logic [7:0] op, input logic z, input logic cf);
    logic tk;
    logic [15:0] exp;
    @(negedge clk);
    cond_code = c; pc_cur = pc; jump_operand = op; acc_zero = z; carry_flag = cf;
    resolve = 1'b1;
    @(negedge clk);
    resolve = 1'b0;
    tk  = model_take(c, z, cf, sense_in);
    exp = tk ? {pc[15:8], op} : pc + 16'd1;
    check(tag, exp, tk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; resolve = 1'b0; cond_code = 4'h0; pc_cur = 16'h0;
    jump_operand = 8'h0; acc_zero = 1'b0; carry_flag = 1'b0; sense_in = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 16'h0000, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 16'h0000, 1'b0);
  endtask

  task automatic t_always_skip;
    resolve_one("R2 always", 4'h0, 16'h3456, 8'h9A, 1'b0, 1'b0);
    resolve_one("R2 always flags set", 4'h0, 16'hA001, 8'h10, 1'b1, 1'b1);
    resolve_one("R3 skip", 4'h8, 16'h3456, 8'h9A, 1'b1, 1'b1);
    resolve_one("R3 skip flags clear", 4'h8, 16'h0100, 8'hFF, 1'b0, 1'b0);
  endtask

  task automatic t_zero_carry;
    for (int v = 0; v < 2; v++) begin
      resolve_one("R4 zero", 4'h2, 16'h2210, 8'h44, v[0], 1'b0);
      resolve_one("R4 nonzero", 4'hA, 16'h2210, 8'h44, v[0], 1'b1);
      resolve_one("R5 carry", 4'h3, 16'h5E20, 8'h07, 1'b0, v[0]);
      resolve_one("R5 no carry", 4'hB, 16'h5E20, 8'h07, 1'b1, v[0]);
    end
  endtask

  task automatic t_sense;
    for (int b = 0; b < 4; b++) begin
      settle_sense(4'(1 << b));
      for (int c = 4; c < 8; c++) begin
        resolve_one("R6 sense high", 4'(c), 16'h7700 + 16'(c), 8'hC0 + 8'(b), 1'b0, 1'b0);
        resolve_one("R6 sense low", 4'(c + 8), 16'h7700 + 16'(c), 8'hC0 + 8'(b), 1'b0, 1'b0);
      end
    end
    settle_sense(4'h0);
  endtask

  task automatic t_undef;
    resolve_one("R7 code1", 4'h1, 16'h4321, 8'h55, 1'b0, 1'b0);
    resolve_one("R7 code9", 4'h9, 16'h4321, 8'h55, 1'b1, 1'b1);
  endtask

  task automatic t_wrap;
    resolve_one("R8 wrap", 4'h8, 16'hFFFF, 8'h12, 1'b0, 1'b0);
    resolve_one("R8 page keep", 4'h0, 16'h12FF, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    resolve_one("R9 taken", 4'h0, 16'h0A0B, 8'h3C, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 pulse drops and pc holds", 16'h0A3C, 1'b0);
    cond_code = 4'h8; pc_cur = 16'hBEEF;
    repeat (3) @(negedge clk);
    check("R9 no resolve holds", 16'h0A3C, 1'b0);
  endtask

  task automatic t_sync;
    @(negedge clk);
    sense_in = 4'b0001;
    cond_code = 4'h4; pc_cur = 16'h6000; jump_operand = 8'h80;
    @(negedge clk);
    resolve = 1'b1;
    @(negedge clk);
    check("R10 second edge sees old", 16'h6001, 1'b0);
    @(negedge clk);
    resolve = 1'b0;
    check("R10 third edge sees new", 16'h6080, 1'b1);
    settle_sense(4'h0);
  endtask

  initial begin
    t_reset();
    t_always_skip();
    t_zero_carry();
    t_sense();
    t_undef();
    t_wrap();
    t_hold();
    t_sync();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule